// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block combines three reset causes into one reset condition and drives it out in both polarities. The causes are a power-fail level from an external supply comparator, a single-cycle timeout pulse from a watchdog, and a manual reset request that has already been debounced. While a level cause is present, reset is held active. Once the last cause clears, reset stays active for a fixed stretch of `STRETCH_MS` millisecond ticks, so the downstream processor always gets a reset of known minimum length. The default is 610 ticks. Any legal setting lies between 250 and 1000.

A free-running one-millisecond tick input sets the time base. The stretch counter advances only on cycles where that tick is high. Any new cause that arrives during the stretch either returns the block to holding (for a level cause) or restarts the count from zero (for a watchdog pulse). The block also passes a supply tolerance choice through to the comparator as its threshold select. It brings out a reset-active status that a watchdog can use to hold off while reset is in progress. After the synchronous initial reset, the outputs start asserted and run one full stretch before they release.

Top module: `rst_pulse_gen`

## Requirements
- R1: `rst_out` and `rst_out_n` are always complementary; `rst_out` high means reset is asserted.
- R2: While `rst_n` is low, `rst_out` is 1. After `rst_n` goes high, `rst_out` stays 1 through `STRETCH_MS`-1 ticks and drops on the cycle after the `STRETCH_MS`-th tick is sampled.
- R3: While `pwr_fail` is 1, `rst_out` is 1 from the next clock edge on, whatever `tick_1ms` does.
- R4: After `pwr_fail` returns to 0 (with no other cause), one clock edge later the stretch begins. `rst_out` stays 1 for exactly `STRETCH_MS` ticks and falls only on an edge where `tick_1ms` was sampled high.
- R5: A one-cycle `wdt_expire` pulse asserts `rst_out` at the next edge and keeps it asserted for exactly `STRETCH_MS` ticks.
- R6: While `mr_req` is 1, reset is held. After `mr_req` is released, reset stays asserted for exactly `STRETCH_MS` ticks.
- R7: A new cause during the stretch re-arms the stretch. A `wdt_expire` pulse restarts the count from zero. A level cause holds reset until it clears, and then a full count follows.
- R8: `thr_sel` equals `tol_sel_in`, where 0 selects the 5% supply threshold and 1 selects the 10% threshold.
- R9: `rst_active` equals `rst_out` at all times.
- R10: When reset is released and no cause is present, ticks leave `rst_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous initial reset, active low |
| tick_1ms | input | 1 | One-cycle pulse each millisecond |
| pwr_fail | input | 1 | Supply below threshold, level, active high |
| wdt_expire | input | 1 | Watchdog timeout, one-cycle pulse |
| mr_req | input | 1 | Debounced manual reset request, level, active high |
| tol_sel_in | input | 1 | Tolerance choice: 0 = 5%, 1 = 10% |
| thr_sel | output | 1 | Threshold select to the comparator |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low |
| rst_active | output | 1 | Reset-in-progress status for watchdog hold-off |

## Verification
The hardest case to reach is a cause that lands in the middle of a stretch, because it takes hundreds of ticks to get there. The bench first runs a partial count with ticks it issues itself. It then injects either a watchdog pulse or a manual request, and counts out a full interval again to show that the count restarted rather than resumed. Exact boundaries are checked one tick before and one tick after the release.

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int STRETCH_MS = 610
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic pwr_fail,
  input  logic wdt_expire,
  input  logic mr_req,
  input  logic tol_sel_in,
  output logic thr_sel,
  output logic rst_out,
  output logic rst_out_n,
  output logic rst_active
);

  localparam int CW = $clog2(STRETCH_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(STRETCH_MS - 1);

  typedef enum logic [1:0] {IDLE, HOLD, STRETCH} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          level_cause;

  assign level_cause = pwr_fail | mr_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= STRETCH;
      cnt <= '0;
    end else if (level_cause) begin
      st  <= HOLD;
      cnt <= '0;
    end else if (wdt_expire || st == HOLD) begin
      st  <= STRETCH;
      cnt <= '0;
    end else if (st == STRETCH && tick_1ms) begin
      if (cnt == LAST) begin
        st  <= IDLE;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rst_out    = (st != IDLE);
  assign rst_out_n  = ~rst_out;
  assign rst_active = rst_out;
  assign thr_sel    = tol_sel_in;

endmodule

// File: rtl/rst_pulse_gen_chk.sv
module rst_pulse_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_1ms,
  input logic pwr_fail,
  input logic wdt_expire,
  input logic mr_req,
  input logic rst_out,
  input logic rst_out_n,
  input logic rst_active
);

  // R1
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out != rst_out_n);

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail || mr_req) |=> rst_out);

  // R5
  wdt_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire |=> rst_out);

  // R4
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> $past(tick_1ms));

  // R10
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out && !pwr_fail && !mr_req && !wdt_expire) |=> !rst_out);

  // R9
  status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active == rst_out);

endmodule

bind rst_pulse_gen rst_pulse_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pwr_fail(pwr_fail),
  .wdt_expire(wdt_expire), .mr_req(mr_req), .rst_out(rst_out),
  .rst_out_n(rst_out_n), .rst_active(rst_active)
);

// File: tb/rst_pulse_gen_bench.sv
module rst_pulse_gen_bench;
  localparam int STR = 610;

  logic clk = 0, rst_n = 0, tick_1ms = 0, pwr_fail = 0, wdt_expire = 0, mr_req = 0, tol_sel_in = 0;
  logic thr_sel, rst_out, rst_out_n, rst_active;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_pulse_gen #(.STRETCH_MS(STR)) u_rst_pulse_gen (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pwr_fail(pwr_fail),
    .wdt_expire(wdt_expire), .mr_req(mr_req), .tol_sel_in(tol_sel_in),
    .thr_sel(thr_sel), .rst_out(rst_out), .rst_out_n(rst_out_n),
    .rst_active(rst_active)
  );

  // {pwr_fail, wdt_expire, mr_req, tol_sel_in, exp_rst, exp_thr}
  localparam logic [5:0] VEC [8] = '{
    6'b0000_00, 6'b0001_01, 6'b1000_10, 6'b0101_11,
    6'b0010_10, 6'b1101_11, 6'b0110_10, 6'b1011_11
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1ms = 1; cyc(); tick_1ms = 0; cyc();
    end
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk_rst(input string tag, input logic exp);
    chk(tag, rst_out, exp);
    chk({tag, " R1"}, rst_out_n, ~exp);
    chk({tag, " R9"}, rst_active, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    cyc(); cyc();
    chk_rst("R2 in reset", 1'b1);
    cyc();
    rst_n = 1;
    cyc();
    chk_rst("R2 after reset", 1'b1);
    ticks(STR - 1);
    chk_rst("R2 one tick short", 1'b1);
    ticks(1);
    chk_rst("R2 released", 1'b0);
    ticks(5);
    chk_rst("R10 idle ticks", 1'b0);

    for (int v = 0; v < 8; v++) begin
      {pwr_fail, wdt_expire, mr_req, tol_sel_in} = VEC[v][5:2];
      cyc();
      wdt_expire = 0;
      chk_rst($sformatf("R3 R5 R6 vec%0d", v), VEC[v][1]);
      chk($sformatf("R8 vec%0d", v), thr_sel, VEC[v][0]);
      pwr_fail = 0; mr_req = 0;
      cyc();
      ticks(STR - 1);
      chk_rst($sformatf("R4 vec%0d short", v), VEC[v][1]);
      ticks(1);
      chk_rst($sformatf("R4 vec%0d end", v), 1'b0);
    end

    pwr_fail = 1; cyc();
    ticks(STR + 5);
    chk_rst("R3 held across ticks", 1'b1);
    pwr_fail = 0; cyc();
    ticks(STR - 1);
    chk_rst("R4 short", 1'b1);
    ticks(1);
    chk_rst("R4 end", 1'b0);

    wdt_expire = 1; cyc(); wdt_expire = 0;
    ticks(300);
    wdt_expire = 1; cyc(); wdt_expire = 0;
    ticks(STR - 1);
    chk_rst("R7 wdt restart short", 1'b1);
    ticks(1);
    chk_rst("R7 wdt restart end", 1'b0);

    wdt_expire = 1; cyc(); wdt_expire = 0;
    ticks(100);
    mr_req = 1; cyc();
    ticks(STR);
    chk_rst("R7 R6 manual held", 1'b1);
    mr_req = 0; cyc();
    ticks(STR - 1);
    chk_rst("R7 R6 manual short", 1'b1);
    ticks(1);
    chk_rst("R7 R6 manual end", 1'b0);

    tol_sel_in = 1; cyc();
    chk("R8 tol high", thr_sel, 1'b1);
    tol_sel_in = 0; cyc();
    chk("R8 tol low", thr_sel, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule